// File: doc/BRIEF.md
# Bidirectional Byte Transceiver with Parity Generation and Checking

This block passes a byte between two bus ports, `a` and `b`. One direction input picks the flow. In transmit, port `a` is copied to port `b`. In receive, port `b` is copied to port `a`. An active-low enable can float every pin the block drives.

The parity pin changes role with the direction:

- **Transmit:** the block drives a parity bit computed from port `a` and an odd/even select.
- **Receive:** the parity pin is an input. The block compares it with port `b` and drives a status pin, which is high when the byte checks out.

The block is purely combinational. Each three-state pin appears as an input value, an output value and an output-enable flag. Pad logic or a bus model outside the block resolves these into real wires.

Top module: `parXcvr`

## Requirements
- R1: With `enN`=0 and `dirTx`=1, `bOut` equals `aIn` bit for bit without inversion, `bOe` is all ones and `aOe` is all zeros.
- R2: With `enN`=0 and `dirTx`=0, `aOut` equals `bIn` bit for bit without inversion, `aOe` is all ones and `bOe` is all zeros.
- R3: With `enN`=1, `aOe`, `bOe`, `parOe` and `okOe` are all 0. `aOut`, `bOut`, `parOut` and `okOut` are also all 0.
- R4: In enabled transmit, `parOe`=1. `parOut`=1 exactly when the count of ones on `aIn` is even and `oddSel`=1, or that count is odd and `oddSel`=0.
- R5: In enabled receive, `parOe`=0 and `parOut`=0. `okOut`=1 exactly when `parIn` equals the bit that R4 would generate from `bIn` and `oddSel`. Otherwise `okOut`=0, which flags an error.
- R6: `okOe` equals the inverse of `enN`. In enabled transmit, `okOut` is held at 1.
- R7: At most one of the two data ports has its output enables set at any time. `parOe` is never set in receive.
- R8: In transmit, `parIn` and `bIn` have no effect on any output. In receive, `aIn` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dirTx | input | 1 | 1 = port a to port b, 0 = port b to port a |
| enN | input | 1 | Active-low enable for all driven pins |
| oddSel | input | 1 | Parity sense select |
| aIn | input | 8 | Value seen on port a |
| aOut | output | 8 | Value driven onto port a |
| aOe | output | 8 | Per-bit drive enable, port a |
| bIn | input | 8 | Value seen on port b |
| bOut | output | 8 | Value driven onto port b |
| bOe | output | 8 | Per-bit drive enable, port b |
| parIn | input | 1 | Value seen on the parity pin |
| parOut | output | 1 | Generated parity bit |
| parOe | output | 1 | Drive enable, parity pin |
| okOut | output | 1 | Check status, 1 = no error |
| okOe | output | 1 | Drive enable, status pin |

## Verification
The hardest situation to reach is a case where a mismatch on an input the current mode should ignore would show up at the outputs. Examples are a stray `parIn` or `bIn` during transmit, or `aIn` changing during receive.

The sweep sets every byte value on the active port. It sets the idle port to the bitwise complement and toggles `parIn` in both directions under both select values. Any leak of the ignored input therefore changes a data or status value that the bench predicts.

A short table of hand-worked vectors pins down the parity sense at both select values. Directed toggles of the enable cover the floating state.

// File: rtl/parXcvrPkg.sv
package parXcvrPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic driveA;   // port a driven
    logic driveB;   // port b driven
    logic drivePar; // parity pin driven
    logic driveOk;  // status pin driven
    logic txMode;   // status forced to no-error
  } xcvrStrobe_t;
endpackage

// File: rtl/parXcvrCtrl.sv
module parXcvrCtrl
  import parXcvrPkg::*;
(
  input  logic        dirTx,
  input  logic        enN,
  output xcvrStrobe_t strobe
);
  logic enabled;

  always_comb begin
    enabled         = ~enN;
    strobe.driveA   = enabled & ~dirTx;
    strobe.driveB   = enabled & dirTx;
    strobe.drivePar = enabled & dirTx;
    strobe.driveOk  = enabled;
    strobe.txMode   = dirTx;
  end
endmodule

// File: rtl/parXcvrData.sv
module parXcvrData
  import parXcvrPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  xcvrStrobe_t       strobe,
  input  logic              oddSel,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              parIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aOe,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bOe,
  output logic              parOut,
  output logic              parOe,
  output logic              okOut,
  output logic              okOe
);
  logic genPar;
  logic chkPar;

  // per-bit pin drivers
  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    always_comb begin
      aOut[i] = strobe.driveA & bIn[i];
      aOe[i]  = strobe.driveA;
      bOut[i] = strobe.driveB & aIn[i];
      bOe[i]  = strobe.driveB;
    end
  end

  always_comb begin
    genPar = (^aIn) ^ oddSel;          // sense from port a
    chkPar = (^bIn) ^ oddSel;          // expected parity of port b
    parOut = strobe.drivePar & genPar;
    parOe  = strobe.drivePar;
    okOe   = strobe.driveOk;
    okOut  = strobe.driveOk & (strobe.txMode | (chkPar == parIn));
  end
endmodule

// File: rtl/parXcvr.sv
module parXcvr
  import parXcvrPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              dirTx,
  input  logic              enN,
  input  logic              oddSel,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aOe,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bOe,
  input  logic              parIn,
  output logic              parOut,
  output logic              parOe,
  output logic              okOut,
  output logic              okOe
);
  xcvrStrobe_t strobe;

  parXcvrCtrl i_ctrl (
    .dirTx (dirTx),
    .enN   (enN),
    .strobe(strobe)
  );

  parXcvrData #(.DATA_W(DATA_W)) i_data (
    .strobe(strobe),
    .oddSel(oddSel),
    .aIn   (aIn),
    .bIn   (bIn),
    .parIn (parIn),
    .aOut  (aOut),
    .aOe   (aOe),
    .bOut  (bOut),
    .bOe   (bOe),
    .parOut(parOut),
    .parOe (parOe),
    .okOut (okOut),
    .okOe  (okOe)
  );
endmodule

// File: rtl/parXcvrChecker.sv
module parXcvrChecker #(
  parameter int DATA_W = 8
) (
  input logic              dirTx,
  input logic              enN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] aOut,
  input logic [DATA_W-1:0] aOe,
  input logic [DATA_W-1:0] bIn,
  input logic [DATA_W-1:0] bOut,
  input logic [DATA_W-1:0] bOe,
  input logic              parOe,
  input logic              parOut,
  input logic              okOut,
  input logic              okOe
);
  always_comb begin
    if (!enN && dirTx) begin
      assert_tx_copy_R1: assert (bOut == aIn && &bOe && aOe == '0);
      assert_tx_ok_high_R6: assert (okOut == 1'b1);
    end
    if (!enN && !dirTx) begin
      assert_rx_copy_R2: assert (aOut == bIn && &aOe && bOe == '0);
    end
    if (enN) begin
      assert_float_R3: assert (aOe == '0 && bOe == '0 && !parOe && !okOe
                              && aOut == '0 && bOut == '0 && !parOut && !okOut);
    end
    assert_ok_enable_R6: assert (okOe == !enN);
    assert_one_port_R7: assert (!((|aOe) && (|bOe)));
    assert_no_par_rx_R7: assert (dirTx || !parOe);
  end
endmodule

bind parXcvr parXcvrChecker #(.DATA_W(DATA_W)) i_parXcvrChecker (
  .dirTx (dirTx),
  .enN   (enN),
  .aIn   (aIn),
  .aOut  (aOut),
  .aOe   (aOe),
  .bIn   (bIn),
  .bOut  (bOut),
  .bOe   (bOe),
  .parOe (parOe),
  .parOut(parOut),
  .okOut (okOut),
  .okOe  (okOe)
);

// File: tb/test_parXcvr.sv
`timescale 1ns/1ps
module test_parXcvr;
  localparam int W = 8;
  // vector: {enN, dirTx, oddSel, parIn, a[7:0], b[7:0], expPar, expOk}
  localparam int VW = 22;
  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h07, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h00, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h01, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h03, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h03, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirTx, enN, oddSel, parIn;
  logic [W-1:0] aIn, bIn, aOut, aOe, bOut, bOe;
  logic parOut, parOe, okOut, okOe;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parXcvr #(.DATA_W(W)) i_parXcvr (
    .dirTx(dirTx), .enN(enN), .oddSel(oddSel),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .parIn(parIn), .parOut(parOut), .parOe(parOe),
    .okOut(okOut), .okOe(okOe)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference parity rule from the requirements: count ones
  function automatic logic refPar(input logic [W-1:0] v, input logic sel);
    int ones = 0;
    for (int k = 0; k < W; k++) ones += int'(v[k]);
    return ((ones % 2) == 0) ? sel : ~sel;
  endfunction

  task automatic apply(input logic e, input logic d, input logic s, input logic p,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    enN = e; dirTx = d; oddSel = s; parIn = p; aIn = a; bIn = b;
    @(negedge clk);
  endtask

  task automatic checkAll(input logic e, input logic d, input logic s, input logic p,
                          input logic [W-1:0] a, input logic [W-1:0] b);
    apply(e, d, s, p, a, b);
    if (d) begin
      check("R1", "bOut", bOut, a);
      check("R1", "bOe", bOe, '1);
      check("R8", "aOut", aOut, '0);
      check("R4", "parOut", {7'd0, parOut}, {7'd0, refPar(a, s)});
      check("R4", "parOe", {7'd0, parOe}, 8'd1);
      check("R6", "okOut", {7'd0, okOut}, 8'd1);
    end else begin
      check("R2", "aOut", aOut, b);
      check("R2", "aOe", aOe, '1);
      check("R7", "bOe", bOe, '0);
      check("R5", "parOe", {7'd0, parOe}, 8'd0);
      check("R5", "okOut", {7'd0, okOut}, {7'd0, (p == refPar(b, s))});
    end
  endtask

  initial begin
    enN = 1'b1; dirTx = 1'b0; oddSel = 1'b0; parIn = 1'b0;
    aIn = '0; bIn = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state: everything floating
    check("R3", "aOe", aOe, '0);
    check("R3", "bOe", bOe, '0);
    check("R3", "pins", {4'd0, parOe, okOe, parOut, okOut}, 8'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] t;
      t = VEC[v];
      apply(t[21], t[20], t[19], t[18], t[17:10], t[9:2]);
      check("R4", "table parOut", {7'd0, parOut}, {7'd0, t[1]});
      check("R5", "table okOut", {7'd0, okOut}, {7'd0, t[0]});
    end

    // full sweep; idle port carries complement to expose leaks (R8)
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          for (int x = 0; x < 256; x++) begin
            logic [W-1:0] v;
            v = W'(x);
            if (d == 1) checkAll(1'b0, 1'b1, s[0], p[0], v, ~v);
            else        checkAll(1'b0, 1'b0, s[0], p[0], ~v, v);
          end

    // R8: changing ignored inputs leaves outputs alone
    apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h00);
    begin
      logic [W-1:0] b0; logic p0, o0;
      b0 = bOut; p0 = parOut; o0 = okOut;
      apply(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3);
      check("R8", "tx bOut stable", bOut, b0);
      check("R8", "tx par/ok stable", {6'd0, parOut, okOut}, {6'd0, p0, o0});
    end
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h81);
    begin
      logic [W-1:0] a0; logic o0;
      a0 = aOut; o0 = okOut;
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h81);
      check("R8", "rx aOut stable", aOut, a0);
      check("R8", "rx ok stable", {7'd0, okOut}, {7'd0, o0});
    end

    // R3 disable in both directions with busy inputs
    for (int d = 0; d < 2; d++) begin
      apply(1'b1, d[0], 1'b1, 1'b1, 8'hFF, 8'hFF);
      check("R3", "aOut|aOe", aOut | aOe, '0);
      check("R3", "bOut|bOe", bOut | bOe, '0);
      check("R6", "okOe", {7'd0, okOe}, 8'd0);
      check("R3", "par", {6'd0, parOe, parOut}, 8'd0);
    end
    // R6 status enable follows enN in receive
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    check("R6", "okOe rx", {7'd0, okOe}, 8'd1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule